// File: doc/BRIEF.md
# Sized Integer Add/Subtract Unit with Status Flags

This block performs the integer add and subtract family of a general-purpose processor datapath. The supported operations are plain add, add with the incoming carry, increment, plain subtract, subtract with the incoming carry as a borrow, decrement and two's-complement negate. Each operation works on a byte, a halfword or a word. Narrow operands sit in the low bits of the 32-bit inputs, and the unit ignores the bits above the selected width. Every operation also produces six status flags: carry, auxiliary carry out of bit 3, sign, zero, even parity of the low byte, and signed overflow. All flags are computed at the selected width.

All seven operations go through one shared carry chain. A small operand stage inverts or substitutes the second operand and chooses the carry-in, and a flag stage derives the six status bits from the chain's inputs, sum and carry out. A two-state controller (`ST_IDLE`, `ST_LOADED`) decides when results are held. An issue strobe at a clock edge captures the result and flags into output registers and moves the controller to `ST_LOADED`. It stays in `ST_LOADED` while issues continue on every edge and returns to `ST_IDLE` on the first edge without one. The `done_valid` output is high exactly in `ST_LOADED`. While no issue arrives, the output registers keep their values.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcode 0 returns A+B and opcode 1 returns A+B+carry_in; the unused opcode 7 behaves exactly like opcode 0; for these the carry flag is the carry out of the selected width.
- R2: Opcode 2 returns A+1 and opcode 5 returns A−1; both leave flag bit 0 (carry) equal to carry_in and update the other five flags.
- R3: Opcode 3 returns A−B and opcode 4 returns A−B−carry_in; the carry flag is set when the subtraction borrows at the selected width.
- R4: Opcode 6 returns 0−A; its carry flag is set exactly when the operand at the selected width is nonzero.
- R5: The flags output packs carry at bit 0, auxiliary carry at bit 1, sign at bit 2, zero at bit 3, parity at bit 4 and overflow at bit 5; parity is 1 when the low 8 bits of the result hold an even number of ones.
- R6: Auxiliary carry is the carry out of bit 3 for the add forms and the borrow out of bit 3 for the subtract forms, negate included.
- R7: Overflow is set when the operands of an add share a sign that the result does not have, or when the operands of a subtract differ in sign and the result's sign differs from the minuend's.
- R8: Size code 0 selects 8 bits, code 1 selects 16 bits, codes 2 and 3 select 32 bits; input bits above the width are ignored, result bits above it are zero, and sign, zero and carry refer to that width.
- R9: An issue at a clock edge makes done_valid high and presents that operation's result and flags after that edge; done_valid is low after any edge without an issue.
- R10: Without an issue, result and flags keep their values.
- R11: During and right after reset, done_valid, result and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Starts an operation at this edge |
| op | input | 3 | Operation code (R1–R4 encodings) |
| size | input | 2 | Operand width select |
| a | input | 32 | First operand / minuend |
| b | input | 32 | Second operand / subtrahend |
| carry_in | input | 1 | Incoming carry flag |
| done_valid | output | 1 | Result registers hold a fresh result |
| result | output | 32 | Registered result, zero above width |
| flags | output | 6 | Registered status flags |

## Verification
Directed vectors target the boundary of each operation: a byte wrapping from 0xFF to zero, the signed edges 0x7F/0x80 and 0x7FFF, a nibble carry from 0x0F, borrow with and without the incoming carry, and negate of zero against negate of a nonzero value. These cases tell apart the carry, overflow and auxiliary carry rules, and they show whether increment and decrement really keep the incoming carry. Narrow operations run with junk in the upper input bits, which exposes any width leak in the result, carry or zero flag. After that, several hundred back-to-back issues with random opcodes (including the unused one), sizes and operands are checked against a width-aware reference model. Idle gaps in between show the difference between holding the outputs and dropping done_valid.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int LANE0_W = 8;
    localparam int NLANE   = 3;
    localparam int XLEN    = LANE0_W << (NLANE - 1);
    localparam int IDX_W   = $clog2(XLEN);
    localparam int NFLAGS  = 6;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_INC  = 3'd2,
        OP_SUB  = 3'd3,
        OP_SBB  = 3'd4,
        OP_DEC  = 3'd5,
        OP_NEG  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } alu_size_e;

    typedef struct packed {
        logic ovf;
        logic par;
        logic zero;
        logic sign;
        logic aux;
        logic carry;
    } alu_flags_t;

    function automatic logic [1:0] lane_of(input alu_size_e s);
        unique case (s)
            SZ_BYTE:  lane_of = 2'd0;
            SZ_HALF:  lane_of = 2'd1;
            default:  lane_of = 2'(NLANE - 1);
        endcase
    endfunction

    function automatic logic [XLEN-1:0] size_mask(input alu_size_e s);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i < (LANE0_W << lane_of(s))) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] msb_of(input alu_size_e s);
        return IDX_W'((LANE0_W << lane_of(s)) - 1);
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import alu_flags_pkg::*;
(
    input  alu_op_e         op,
    input  alu_size_e       size,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            carry_in,
    output logic [XLEN-1:0] x,
    output logic [XLEN-1:0] y,
    output logic            cin,
    output logic            is_sub,
    output logic            keep_cf
);
    logic [XLEN-1:0] x_raw, y_raw;
    logic [XLEN-1:0] mask;

    assign mask = size_mask(size);

    always_comb begin
        x_raw   = a;
        y_raw   = b;
        cin     = 1'b0;
        is_sub  = 1'b0;
        keep_cf = 1'b0;
        unique case (op)
            OP_ADD, OP_RSVD: begin
            end
            OP_ADC: cin = carry_in;
            OP_INC: begin
                y_raw   = '0;
                cin     = 1'b1;
                keep_cf = 1'b1;
            end
            OP_SUB: begin
                y_raw  = ~b;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBB: begin
                y_raw  = ~b;
                cin    = ~carry_in;
                is_sub = 1'b1;
            end
            OP_DEC: begin
                y_raw   = '1;
                is_sub  = 1'b1;
                keep_cf = 1'b1;
            end
            OP_NEG: begin
                x_raw  = '0;
                y_raw  = ~a;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
        endcase
    end

    assign x = x_raw & mask;
    assign y = y_raw & mask;
endmodule

// File: rtl/alu_adder_core.sv
module alu_adder_core
    import alu_flags_pkg::*;
(
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            cin,
    input  alu_size_e       size,
    output logic [XLEN-1:0] sum,
    output logic            cout
);
    logic [XLEN:0]      sum_ext;
    logic [NLANE-1:0]   tap;
    logic [1:0]         lane;

    assign sum_ext = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};

    for (genvar g = 0; g < NLANE; g++) begin : g_tap
        assign tap[g] = sum_ext[LANE0_W << g];
    end

    assign lane = lane_of(size);
    assign cout = tap[lane];
    assign sum  = sum_ext[XLEN-1:0] & size_mask(size);
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flags_pkg::*;
(
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic [XLEN-1:0] sum,
    input  logic            cout,
    input  logic            is_sub,
    input  logic            keep_cf,
    input  logic            carry_in,
    input  alu_size_e       size,
    output alu_flags_t      flg
);
    logic [IDX_W-1:0] top;
    logic             x_top, y_top, s_top;

    assign top   = msb_of(size);
    assign x_top = x[top];
    assign y_top = y[top];
    assign s_top = sum[top];

    always_comb begin
        flg.carry = keep_cf ? carry_in : (cout ^ is_sub);
        flg.aux   = x[4] ^ y[4] ^ sum[4] ^ is_sub;
        flg.sign  = s_top;
        flg.zero  = (sum == '0);
        flg.par   = ~^sum[7:0];
        flg.ovf   = (x_top == y_top) && (s_top != x_top);
    end
endmodule

// File: rtl/alu_issue_ctrl.sv
module alu_issue_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_valid,
    output logic load_en,
    output logic done_valid
);
    typedef enum logic {ST_IDLE = 1'b0, ST_LOADED = 1'b1} ctl_state_e;

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = issue_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = issue_valid ? ST_LOADED : ST_IDLE;
        endcase
    end

    always_comb begin
        load_en    = issue_valid && rst_n;
        done_valid = (state_q == ST_LOADED);
    end

    a_r9_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> done_valid);
    a_r9_low_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !done_valid);
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_valid,
    input  logic [2:0]  op,
    input  logic [1:0]  size,
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic        carry_in,
    output logic        done_valid,
    output logic [31:0] result,
    output logic [5:0]  flags
);
    alu_op_e         op_e;
    alu_size_e       size_e;
    logic [XLEN-1:0] x, y, sum;
    logic            cin, is_sub, keep_cf, cout, load_en;
    alu_flags_t      flg_d, flg_q;
    logic [XLEN-1:0] res_q;

    assign op_e   = alu_op_e'(op);
    assign size_e = alu_size_e'(size);

    alu_operand_prep u_prep (
        .op(op_e), .size(size_e), .a(a), .b(b), .carry_in(carry_in),
        .x(x), .y(y), .cin(cin), .is_sub(is_sub), .keep_cf(keep_cf)
    );

    alu_adder_core u_add (
        .x(x), .y(y), .cin(cin), .size(size_e), .sum(sum), .cout(cout)
    );

    alu_flag_gen u_flag (
        .x(x), .y(y), .sum(sum), .cout(cout), .is_sub(is_sub),
        .keep_cf(keep_cf), .carry_in(carry_in), .size(size_e), .flg(flg_d)
    );

    alu_issue_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .load_en(load_en), .done_valid(done_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (load_en) begin
            res_q <= sum;
            flg_q <= flg_d;
        end
    end

    assign result = res_q;
    assign flags  = flg_q;

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ($stable(result) && $stable(flags)));
    a_r2_incdec_keep_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (op == 3'd2 || op == 3'd5)) |=> (flags[0] == $past(carry_in)));
    a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && size == 2'd0) |=> (result[31:8] == 24'd0));
    a_r4_neg_zero_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == 3'd6 && a == 32'd0) |=> (!flags[0] && flags[3]));
    a_r5_parity_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (flags[4] == ~^result[7:0]));
    a_r5_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (flags[3] == (result == 32'd0)));
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done_valid && result == 32'd0 && flags == 6'd0));
endmodule

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] a = '0, b = '0;
    logic        carry_in = 1'b0;
    logic        done_valid;
    logic [31:0] result;
    logic [5:0]  flags;

    int total = 0;
    int bad = 0;
    logic [37:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    alu_flags_unit u_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op(op), .size(size),
        .a(a), .b(b), .carry_in(carry_in), .done_valid(done_valid),
        .result(result), .flags(flags)
    );

    // flags packing per R5: {ovf, par, zero, sign, aux, carry}
    function automatic logic [37:0] ref_calc(input logic [2:0] o, input logic [1:0] s,
                                             input logic [31:0] ai, input logic [31:0] bi,
                                             input logic cf);
        logic [63:0] mask, am, bm, sa, sb, r;
        logic c, sub, ovf;
        int w;
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        am = {32'd0, ai} & mask;
        bm = {32'd0, bi} & mask;
        sa = am; sb = bm; sub = 1'b0; c = 1'b0; r = '0;
        case (o)
            3'd1: begin r = am + bm + {63'd0, cf}; c = r[w]; end
            3'd2: begin sb = 64'd1; r = am + 64'd1; c = cf; end
            3'd3: begin r = am - bm; c = am < bm; sub = 1'b1; end
            3'd4: begin r = am - bm - {63'd0, cf}; c = am < (bm + {63'd0, cf}); sub = 1'b1; end
            3'd5: begin sb = 64'd1; r = am - 64'd1; c = cf; sub = 1'b1; end
            3'd6: begin sa = 64'd0; sb = am; r = 64'd0 - am; c = (am != 64'd0); sub = 1'b1; end
            default: begin r = am + bm; c = r[w]; end
        endcase
        r = r & mask;
        if (sub) ovf = (sa[w-1] != sb[w-1]) && (r[w-1] != sa[w-1]);
        else     ovf = (sa[w-1] == sb[w-1]) && (r[w-1] != sa[w-1]);
        return {ovf, ~^r[7:0], (r == 64'd0), r[w-1], sa[4] ^ sb[4] ^ r[4], c, r[31:0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [2:0] o, input logic [1:0] s,
                         input logic [31:0] ai, input logic [31:0] bi, input logic cf);
        @(negedge clk);
        issue_valid = 1'b1; op = o; size = s; a = ai; b = bi; carry_in = cf;
        exp_q.push_back(ref_calc(o, s, ai, bi, cf));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            op = 3'($urandom); size = 2'($urandom); a = $urandom; b = $urandom;
            carry_in = 1'($urandom);
        end
    endtask

    // monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected done_valid", 64'd1, 64'd0);
            end else begin
                logic [37:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {26'd0, flags, result}, {26'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [37:0] last;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {31'd0, done_valid, result}, 64'd0);
        check("R11 reset flags", {58'd0, flags}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {25'd0, done_valid, flags, result}, 64'd0);

        drive("R1 add byte 7F+01", 3'd0, 2'd0, 32'h7F, 32'h01, 1'b0);
        drive("R1 adc half with cf", 3'd1, 2'd1, 32'hFFFF, 32'h0000, 1'b1);
        drive("R1 reserved opcode as add", 3'd7, 2'd2, 32'h8000_0000, 32'h8000_0000, 1'b1);
        drive("R2 inc byte FF keeps cf", 3'd2, 2'd0, 32'hFF, 32'h55, 1'b1);
        drive("R2 dec byte 00 keeps cf", 3'd5, 2'd0, 32'h00, 32'h00, 1'b0);
        drive("R3 sub byte borrow", 3'd3, 2'd0, 32'h05, 32'h07, 1'b0);
        drive("R3 sbb word borrow via cf", 3'd4, 2'd2, 32'h10, 32'h10, 1'b1);
        drive("R3 sbb word no borrow", 3'd4, 2'd2, 32'h11, 32'h10, 1'b1);
        drive("R4 neg zero", 3'd6, 2'd1, 32'hABCD_0000, 32'h0, 1'b1);
        drive("R4 neg nonzero", 3'd6, 2'd0, 32'h05, 32'h0, 1'b0);
        drive("R5 parity even", 3'd0, 2'd0, 32'h03, 32'h00, 1'b0);
        drive("R5 parity odd", 3'd0, 2'd0, 32'h01, 32'h00, 1'b0);
        drive("R6 aux carry 0F+01", 3'd0, 2'd0, 32'h0F, 32'h01, 1'b0);
        drive("R6 aux borrow 10-01", 3'd3, 2'd0, 32'h10, 32'h01, 1'b0);
        drive("R7 overflow half 7FFF+1", 3'd2, 2'd1, 32'h7FFF, 32'h0, 1'b0);
        drive("R7 overflow sub 80-01", 3'd3, 2'd0, 32'h80, 32'h01, 1'b0);
        drive("R8 byte ignores upper bits", 3'd0, 2'd0, 32'hABCD_12FF, 32'h1234_5601, 1'b0);
        drive("R8 size code 3 is word", 3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 1'b0);
        last = ref_calc(3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 1'b0);
        idle(1);
        @(negedge clk);
        check("R9 done_valid low after gap", {63'd0, done_valid}, 64'd0);
        idle(3);
        check("R10 result held", {26'd0, flags, result}, {26'd0, last});

        for (int i = 0; i < 400; i++) begin
            drive("R9 random stream", 3'($urandom), 2'($urandom), $urandom, $urandom,
                  1'($urandom));
            if (i % 37 == 36) idle(2);
        end
        idle(4);
        check("R9 queue drained", {32'd0, 32'(exp_q.size())}, 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule